// File: doc/BRIEF.md
# SPI NOR Flash Transaction Monitor

This block watches a serial flash bus from the side and reports, in a decoded form, what each transaction on it does. It does not see the serial clock or the raw pins. A sniffer front end hands it one event per completed byte: a strobe with the byte shifted out by the controller and the byte shifted back by the flash. A separate strobe marks every edge of the chip select. From these the monitor works out which byte of the transaction it is looking at and decodes the command. It also assembles the 24-bit address and passes the payload bytes on.

Each decoded item comes out as a one-cycle pulse in the same clock cycle as the byte event that completes it: command, address, data, unknown-command flag and misaligned-erase warning. When chip select moves after a read or program that carried payload, a summary pulse gives the command, its start address and the number of payload bytes. For the dual-I/O read, each byte event carries two bits per clock, one on each line. The monitor splits these back into two plain bytes.

Top module: `spi_flash_txn_monitor`

## Requirements
- R1: The first byte event after reset or after any chip-select strobe is the command. If `mosi_byte` is one of 0x03 (read), 0x0B (fast read), 0xBB (dual-I/O read), 0x02 (page program), 0x20 (sector erase), 0x05 (status read), 0x06 (write enable), 0x04 (write disable) or 0x9F (identify), `cmd_vld` pulses in that cycle and `cmd_code` equals the byte.
- R2: For read, fast read, page program and sector erase, bytes 2, 3 and 4 carry the address on `mosi_byte`, highest byte first. `addr_vld` pulses only on byte 4, and `addr_out` then shows the full 24-bit address.
- R3: Read payload starts at byte 5. Fast read treats byte 5 as a dummy that produces no event, and its payload starts at byte 6.
- R4: Payload of read and fast read comes from `miso_byte`. Payload of page program comes from `mosi_byte`. It appears on `data_first` with `data_vld` high and `data_pair` low, for every byte until chip select moves.
- R5: Dual-I/O read de-interleaving: output bit 2k is taken from a `mosi_byte` bit and output bit 2k+1 from a `miso_byte` bit. `data_first` is built from bits 7..4 of both bytes and `data_second` from bits 3..0. Byte 2 gives address bits 23..16 (first) and 15..8 (second). Byte 3 gives bits 7..0 (first) and a dummy (second), and `addr_vld` pulses there. Payload starts at byte 4, with `data_vld` and `data_pair` both high.
- R6: A sector erase whose address has any of bits 11..0 set pulses `erase_misalign` together with `addr_vld` on byte 4. An aligned address gives no warning. Bytes after byte 4 of an erase produce no event.
- R7: A command byte not listed in R1 pulses `unk_cmd` instead of `cmd_vld`. Every later byte of that transaction produces no event, and no summary follows.
- R8: On a chip-select strobe, `sum_vld` pulses in that same cycle if and only if the transaction now ending was a read, fast read, dual read or program that produced at least one payload event. The pulse carries `sum_op` (command), `sum_addr` (address) and `sum_cnt` (payload bytes, two per dual event).
- R9: The payload count saturates at 65535 and does not wrap.
- R10: A chip-select strobe resets the byte position and the address. A byte event in the same cycle as the strobe is ignored, so the next byte event is a command.
- R11: Status read, write enable, write disable and identify produce only the command pulse. Their later bytes produce no address, data or summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | One byte pair completed on the bus |
| mosi_byte | input | 8 | Byte driven by the controller (even bits in dual mode) |
| miso_byte | input | 8 | Byte driven by the flash (odd bits in dual mode) |
| cs_chg | input | 1 | Chip select changed level |
| cmd_vld | output | 1 | Known command seen |
| cmd_code | output | 8 | Command byte, valid with cmd_vld |
| unk_cmd | output | 1 | Unknown command seen |
| addr_vld | output | 1 | Address complete |
| addr_out | output | 24 | Assembled address, valid with addr_vld |
| erase_misalign | output | 1 | Sector erase address not 4096-aligned |
| data_vld | output | 1 | Payload event |
| data_pair | output | 1 | Payload event carries two bytes |
| data_first | output | 8 | First (or only) payload byte |
| data_second | output | 8 | Second payload byte in dual mode |
| sum_vld | output | 1 | Transaction summary pulse |
| sum_op | output | 8 | Command of the finished transaction |
| sum_addr | output | 24 | Start address of the finished transaction |
| sum_cnt | output | 16 | Payload byte count, saturating |

## Verification
The checker watches properties that hold on every cycle. Every decoded event must coincide with an accepted byte event, and at most one kind of event appears per byte. A summary appears only on a chip-select strobe and always has a non-zero count. The payload count never falls except on a strobe, and it is zero right after one. A misalignment warning always sits on an address with low bits set. The bench scenarios cover what a cycle-local property cannot show: the byte number at which each command's address and payload begin, the dummy phases, the exact de-interleaved values, the address and count carried in the summary, the silence after unknown and simple commands, and the saturation of the count after 65540 payload bytes.

// File: rtl/spimon_pkg.sv
package spimon_pkg;

  localparam int ADDR_W = 24;

  localparam logic [7:0] OP_RD     = 8'h03;
  localparam logic [7:0] OP_RD_FST = 8'h0B;
  localparam logic [7:0] OP_RD_DIO = 8'hBB;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_STAT   = 8'h05;
  localparam logic [7:0] OP_WEN    = 8'h06;
  localparam logic [7:0] OP_WDIS   = 8'h04;
  localparam logic [7:0] OP_IDENT  = 8'h9F;

  typedef enum logic [2:0] {
    CL_IDLE, CL_RD, CL_RD_FST, CL_RD_DIO, CL_PROG, CL_ERASE, CL_PLAIN, CL_UNKNOWN
  } cmd_cls_e;

  function automatic cmd_cls_e classify(input logic [7:0] op);
    case (op)
      OP_RD:     return CL_RD;
      OP_RD_FST: return CL_RD_FST;
      OP_RD_DIO: return CL_RD_DIO;
      OP_PROG:   return CL_PROG;
      OP_ERASE:  return CL_ERASE;
      OP_STAT, OP_WEN, OP_WDIS, OP_IDENT: return CL_PLAIN;
      default:   return CL_UNKNOWN;
    endcase
  endfunction

  // even nibble bits go to even output positions, odd nibble to odd
  function automatic logic [7:0] weave(input logic [3:0] even_n, input logic [3:0] odd_n);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) begin
      r[2*i]   = even_n[i];
      r[2*i+1] = odd_n[i];
    end
    return r;
  endfunction

  // place byte slot 0 (top) .. 2 (bottom) into a 24-bit address
  function automatic logic [ADDR_W-1:0] place_byte(input logic [ADDR_W-1:0] a,
                                                   input logic [1:0] slot,
                                                   input logic [7:0] b);
    logic [ADDR_W-1:0] r;
    r = a;
    case (slot)
      2'd0:    r[23:16] = b;
      2'd1:    r[15:8]  = b;
      default: r[7:0]   = b;
    endcase
    return r;
  endfunction

  function automatic logic is_payload_cls(input cmd_cls_e c);
    return (c == CL_RD) || (c == CL_RD_FST) || (c == CL_RD_DIO) || (c == CL_PROG);
  endfunction

endpackage

// File: rtl/spimon_phase.sv
module spimon_phase
  import spimon_pkg::*;
#(
  parameter int POS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             cs_chg,
  input  logic [7:0]       mosi,
  output logic             take,
  output logic [POS_W-1:0] byte_num,
  output cmd_cls_e         cls,
  output logic [7:0]       opc,
  output logic             cmd_pulse,
  output logic             unk_pulse
);
  localparam logic [POS_W-1:0] SEEN_MAX = POS_W'(2**POS_W - 2);

  logic [POS_W-1:0] seen_q;
  cmd_cls_e         cls_q;
  logic [7:0]       opc_q;
  logic             op_byte;
  cmd_cls_e         new_cls;

  assign take     = byte_vld & ~cs_chg;
  assign op_byte  = take & (seen_q == '0);
  assign byte_num = seen_q + POS_W'(1);
  assign new_cls  = classify(mosi);
  assign cls      = cls_q;
  assign opc      = opc_q;

  assign cmd_pulse = op_byte & (new_cls != CL_UNKNOWN);
  assign unk_pulse = op_byte & (new_cls == CL_UNKNOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      cls_q  <= CL_IDLE;
      opc_q  <= '0;
    end else if (cs_chg) begin
      seen_q <= '0;
      cls_q  <= CL_IDLE;
    end else if (take) begin
      if (seen_q != SEEN_MAX) seen_q <= seen_q + POS_W'(1);
      if (op_byte) begin
        cls_q <= new_cls;
        opc_q <= mosi;
      end
    end
  end

endmodule

// File: rtl/spimon_addr.sv
module spimon_addr
  import spimon_pkg::*;
#(
  parameter int POS_W     = 3,
  parameter int SECTOR_LG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_chg,
  input  logic              take,
  input  logic [POS_W-1:0]  byte_num,
  input  cmd_cls_e          cls,
  input  logic [7:0]        mosi,
  input  logic [7:0]        miso,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_full,
  output logic              addr_pulse,
  output logic              misalign_pulse
);
  logic [ADDR_W-1:0] nxt;
  logic              done;
  logic [7:0]        w_hi, w_lo;

  assign w_hi = weave(mosi[7:4], miso[7:4]);
  assign w_lo = weave(mosi[3:0], miso[3:0]);

  always_comb begin
    nxt  = addr_q;
    done = 1'b0;
    case (cls)
      CL_RD, CL_RD_FST, CL_PROG, CL_ERASE: begin
        if (byte_num >= POS_W'(2) && byte_num <= POS_W'(4))
          nxt = place_byte(addr_q, 2'(byte_num - POS_W'(2)), mosi);
        done = (byte_num == POS_W'(4));
      end
      CL_RD_DIO: begin
        if (byte_num == POS_W'(2)) nxt = {w_hi, w_lo, addr_q[7:0]};
        if (byte_num == POS_W'(3)) nxt = place_byte(addr_q, 2'd2, w_hi);
        done = (byte_num == POS_W'(3));
      end
      default: ;
    endcase
  end

  assign addr_full      = nxt;
  assign addr_pulse     = take & done;
  assign misalign_pulse = addr_pulse & (cls == CL_ERASE) & (|nxt[SECTOR_LG-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (cs_chg) addr_q <= '0;
    else if (take)   addr_q <= nxt;
  end

endmodule

// File: rtl/spimon_data.sv
module spimon_data
  import spimon_pkg::*;
#(
  parameter int POS_W = 3,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_chg,
  input  logic              take,
  input  logic [POS_W-1:0]  byte_num,
  input  cmd_cls_e          cls,
  input  logic [7:0]        opc,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [7:0]        mosi,
  input  logic [7:0]        miso,
  output logic              data_pulse,
  output logic              pair,
  output logic [7:0]        first_b,
  output logic [7:0]        second_b,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              sum_pulse,
  output logic [7:0]        sum_op,
  output logic [ADDR_W-1:0] sum_addr,
  output logic [CNT_W-1:0]  sum_cnt
);
  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] c, input logic [1:0] inc);
    logic [CNT_W:0] s;
    s = {1'b0, c} + (CNT_W+1)'(inc);
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  logic [POS_W-1:0] start_b;
  logic             had_data_q;

  always_comb begin
    case (cls)
      CL_RD, CL_PROG: start_b = POS_W'(5);
      CL_RD_FST:      start_b = POS_W'(6);
      CL_RD_DIO:      start_b = POS_W'(4);
      default:        start_b = '0;
    endcase
  end

  assign data_pulse = take & is_payload_cls(cls) & (byte_num >= start_b);
  assign pair       = data_pulse & (cls == CL_RD_DIO);

  always_comb begin
    case (cls)
      CL_PROG:   first_b = mosi;
      CL_RD_DIO: first_b = weave(mosi[7:4], miso[7:4]);
      default:   first_b = miso;
    endcase
    second_b = (cls == CL_RD_DIO) ? weave(mosi[3:0], miso[3:0]) : 8'h00;
  end

  assign sum_pulse = cs_chg & had_data_q;
  assign sum_op    = opc;
  assign sum_addr  = addr_q;
  assign sum_cnt   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      had_data_q <= 1'b0;
    end else if (cs_chg) begin
      cnt_q      <= '0;
      had_data_q <= 1'b0;
    end else if (data_pulse) begin
      cnt_q      <= sat_add(cnt_q, pair ? 2'd2 : 2'd1);
      had_data_q <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_flash_txn_monitor.sv
module spi_flash_txn_monitor
  import spimon_pkg::*;
#(
  parameter int POS_W     = 3,
  parameter int CNT_W     = 16,
  parameter int SECTOR_LG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        mosi_byte,
  input  logic [7:0]        miso_byte,
  input  logic              cs_chg,
  output logic              cmd_vld,
  output logic [7:0]        cmd_code,
  output logic              unk_cmd,
  output logic              addr_vld,
  output logic [ADDR_W-1:0] addr_out,
  output logic              erase_misalign,
  output logic              data_vld,
  output logic              data_pair,
  output logic [7:0]        data_first,
  output logic [7:0]        data_second,
  output logic              sum_vld,
  output logic [7:0]        sum_op,
  output logic [ADDR_W-1:0] sum_addr,
  output logic [CNT_W-1:0]  sum_cnt
);
  logic              take;
  logic [POS_W-1:0]  byte_num;
  cmd_cls_e          cls;
  logic [7:0]        opc;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_now;

  assign cmd_code = mosi_byte;

  spimon_phase #(.POS_W(POS_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .cs_chg(cs_chg), .mosi(mosi_byte),
    .take(take), .byte_num(byte_num), .cls(cls), .opc(opc),
    .cmd_pulse(cmd_vld), .unk_pulse(unk_cmd)
  );

  spimon_addr #(.POS_W(POS_W), .SECTOR_LG(SECTOR_LG)) u_addr (
    .clk(clk), .rst_n(rst_n), .cs_chg(cs_chg), .take(take), .byte_num(byte_num),
    .cls(cls), .mosi(mosi_byte), .miso(miso_byte), .addr_q(addr_q),
    .addr_full(addr_out), .addr_pulse(addr_vld), .misalign_pulse(erase_misalign)
  );

  spimon_data #(.POS_W(POS_W), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rst_n(rst_n), .cs_chg(cs_chg), .take(take), .byte_num(byte_num),
    .cls(cls), .opc(opc), .addr_q(addr_q), .mosi(mosi_byte), .miso(miso_byte),
    .data_pulse(data_vld), .pair(data_pair), .first_b(data_first), .second_b(data_second),
    .cnt_q(cnt_now), .sum_pulse(sum_vld), .sum_op(sum_op), .sum_addr(sum_addr),
    .sum_cnt(sum_cnt)
  );

endmodule

// File: rtl/spimon_checker.sv
module spimon_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             cs_chg,
  input logic             cmd_vld,
  input logic             unk_cmd,
  input logic             addr_vld,
  input logic [11:0]      addr_low,
  input logic             erase_misalign,
  input logic             data_vld,
  input logic             data_pair,
  input logic             sum_vld,
  input logic [CNT_W-1:0] sum_cnt,
  input logic [CNT_W-1:0] cnt_now
);
  AST_EVENT_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld || unk_cmd || addr_vld || data_vld) |-> (byte_vld && !cs_chg)); // R10

  AST_ONE_EVENT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_vld, unk_cmd, addr_vld, data_vld})); // R1

  AST_SUM_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sum_vld |-> cs_chg); // R8

  AST_SUM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sum_vld |-> (sum_cnt != '0)); // R8

  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_chg |=> (cnt_now == '0)); // R10

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_chg |=> (cnt_now >= $past(cnt_now))); // R9

  AST_MISALIGN_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    erase_misalign |-> (addr_vld && addr_low != 12'h000)); // R6

  AST_PAIR_IS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    data_pair |-> data_vld); // R5

endmodule

bind spi_flash_txn_monitor spimon_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .cs_chg(cs_chg),
  .cmd_vld(cmd_vld), .unk_cmd(unk_cmd), .addr_vld(addr_vld), .addr_low(addr_out[11:0]),
  .erase_misalign(erase_misalign), .data_vld(data_vld), .data_pair(data_pair),
  .sum_vld(sum_vld), .sum_cnt(sum_cnt), .cnt_now(cnt_now)
);

// File: tb/spi_flash_txn_monitor_bench.sv
`timescale 1ns/1ps
module spi_flash_txn_monitor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 1'b0;
  logic [7:0] mosi_byte = 8'h00, miso_byte = 8'h00;
  logic cs_chg = 1'b0;
  logic cmd_vld, unk_cmd, addr_vld, erase_misalign, data_vld, data_pair, sum_vld;
  logic [7:0] cmd_code, data_first, data_second, sum_op;
  logic [23:0] addr_out, sum_addr;
  logic [15:0] sum_cnt;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  // captured outputs of the last driven cycle
  logic c_cmd, c_unk, c_addr, c_mis, c_data, c_pair, c_sum;
  logic [7:0] c_code, c_first, c_second, c_sop;
  logic [23:0] c_aout, c_saddr;
  logic [15:0] c_scnt;

  always #2.5 clk = ~clk;

  spi_flash_txn_monitor u_spi_flash_txn_monitor (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .mosi_byte(mosi_byte),
    .miso_byte(miso_byte), .cs_chg(cs_chg), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .unk_cmd(unk_cmd), .addr_vld(addr_vld), .addr_out(addr_out),
    .erase_misalign(erase_misalign), .data_vld(data_vld), .data_pair(data_pair),
    .data_first(data_first), .data_second(data_second), .sum_vld(sum_vld),
    .sum_op(sum_op), .sum_addr(sum_addr), .sum_cnt(sum_cnt)
  );

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 190000", cycles);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic capture();
    c_cmd = cmd_vld; c_unk = unk_cmd; c_addr = addr_vld; c_mis = erase_misalign;
    c_data = data_vld; c_pair = data_pair; c_sum = sum_vld; c_code = cmd_code;
    c_first = data_first; c_second = data_second; c_sop = sum_op;
    c_aout = addr_out; c_saddr = sum_addr; c_scnt = sum_cnt;
  endtask

  task automatic send(input logic [7:0] m, input logic [7:0] s);
    @(negedge clk);
    byte_vld = 1'b1; mosi_byte = m; miso_byte = s;
    #1 capture();
    @(posedge clk);
    #1 byte_vld = 1'b0;
  endtask

  task automatic cs_edge();
    @(negedge clk);
    cs_chg = 1'b1;
    #1 capture();
    @(posedge clk);
    #1 cs_chg = 1'b0;
  endtask

  function automatic logic [7:0] exp_weave(input logic [7:0] m, input logic [7:0] s, input bit upper);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) begin
      int src = (k / 2) + (upper ? 4 : 0);
      r[k] = (k % 2 == 1) ? s[src] : m[src];
    end
    return r;
  endfunction

  function automatic bit quiet();
    return !(c_cmd || c_unk || c_addr || c_data || c_mis);
  endfunction

  task automatic t_reset();
    @(negedge clk); #1 capture();
    chk(quiet() && !c_sum, "R1 reset idle", {c_cmd, c_unk, c_addr, c_data, c_sum}, 0);
    send(8'h03, 8'hFF);
    chk(c_cmd && c_code == 8'h03, "R1 first byte after reset is command", c_code, 8'h03);
    cs_edge();
    chk(!c_sum, "R8 no summary without payload", c_sum, 0);
  endtask

  task automatic t_read();
    cs_edge();
    send(8'h03, 8'h00);
    chk(c_cmd && c_code == 8'h03, "R1 read command", c_code, 8'h03);
    send(8'h12, 8'h00);
    chk(!c_addr, "R2 no address at byte 2", c_addr, 0);
    send(8'h34, 8'h00);
    chk(!c_addr, "R2 no address at byte 3", c_addr, 0);
    send(8'h56, 8'h99);
    chk(c_addr && c_aout == 24'h123456, "R2 read address at byte 4", c_aout, 24'h123456);
    chk(!c_data, "R3 no data at byte 4", c_data, 0);
    send(8'h00, 8'hA1);
    chk(c_data && !c_pair && c_first == 8'hA1, "R3 R4 read data at byte 5 from miso", c_first, 8'hA1);
    send(8'h77, 8'hB2);
    chk(c_data && c_first == 8'hB2, "R4 read data byte 6", c_first, 8'hB2);
    for (int i = 0; i < 8; i++) send(8'h00, 8'(i));
    chk(c_data && c_first == 8'h07, "R4 read data continues", c_first, 8'h07);
    cs_edge();
    chk(c_sum && c_sop == 8'h03 && c_saddr == 24'h123456, "R8 read summary op/addr",
        {c_sop, c_saddr}, {8'h03, 24'h123456});
    chk(c_scnt == 16'd10, "R8 read summary count", c_scnt, 10);
  endtask

  task automatic t_fast();
    cs_edge();
    send(8'h0B, 8'h00);
    send(8'hAB, 8'h00); send(8'hCD, 8'h00); send(8'hEF, 8'h00);
    chk(c_addr && c_aout == 24'hABCDEF, "R2 fast read address", c_aout, 24'hABCDEF);
    send(8'h00, 8'h5A);
    chk(quiet(), "R3 fast read dummy byte 5 silent", c_data, 0);
    send(8'h00, 8'h6B);
    chk(c_data && c_first == 8'h6B, "R3 fast read data at byte 6", c_first, 8'h6B);
    cs_edge();
    chk(c_sum && c_sop == 8'h0B && c_scnt == 16'd1, "R8 fast read summary", {c_sop, c_scnt}, {8'h0B, 16'd1});
  endtask

  task automatic t_prog();
    cs_edge();
    send(8'h02, 8'h00);
    send(8'h00, 8'h11); send(8'h01, 8'h22); send(8'h00, 8'h33);
    chk(c_addr && c_aout == 24'h000100, "R2 program address", c_aout, 24'h000100);
    send(8'hC3, 8'h3C);
    chk(c_data && c_first == 8'hC3, "R4 program data from mosi", c_first, 8'hC3);
    send(8'h5E, 8'hE5);
    cs_edge();
    chk(c_sum && c_sop == 8'h02 && c_saddr == 24'h000100 && c_scnt == 16'd2, "R8 program summary",
        c_scnt, 2);
  endtask

  task automatic t_dual();
    logic [23:0] ea;
    cs_edge();
    send(8'hBB, 8'h00);
    chk(c_cmd && c_code == 8'hBB, "R1 dual command", c_code, 8'hBB);
    send(8'h9C, 8'h63);
    ea[23:16] = exp_weave(8'h9C, 8'h63, 1); ea[15:8] = exp_weave(8'h9C, 8'h63, 0);
    chk(!c_addr, "R5 dual no address at byte 2", c_addr, 0);
    send(8'hA5, 8'h0F);
    ea[7:0] = exp_weave(8'hA5, 8'h0F, 1);
    chk(c_addr && c_aout == ea, "R5 dual address at byte 3", c_aout, ea);
    chk(!c_data, "R5 dual no data at byte 3", c_data, 0);
    send(8'h3A, 8'hD4);
    chk(c_data && c_pair && c_first == exp_weave(8'h3A, 8'hD4, 1), "R5 dual first byte",
        c_first, exp_weave(8'h3A, 8'hD4, 1));
    chk(c_second == exp_weave(8'h3A, 8'hD4, 0), "R5 dual second byte",
        c_second, exp_weave(8'h3A, 8'hD4, 0));
    send(8'hF0, 8'h00);
    chk(c_first == 8'h55 && c_second == 8'h00, "R5 dual even bits from mosi",
        {c_first, c_second}, 16'h5500);
    cs_edge();
    chk(c_sum && c_sop == 8'hBB && c_saddr == ea && c_scnt == 16'd4, "R5 R8 dual summary",
        c_scnt, 4);
  endtask

  task automatic t_erase();
    cs_edge();
    send(8'h20, 8'h00); send(8'h04, 8'h00); send(8'h30, 8'h00); send(8'h00, 8'h00);
    chk(c_addr && !c_mis, "R6 aligned erase no warning", c_mis, 0);
    send(8'h12, 8'h34);
    chk(quiet(), "R6 erase extra byte silent", c_data, 0);
    cs_edge();
    chk(!c_sum, "R6 R8 erase no summary", c_sum, 0);
    send(8'h20, 8'h00); send(8'h00, 8'h00); send(8'h10, 8'h00); send(8'h01, 8'h00);
    chk(c_addr && c_mis && c_aout == 24'h001001, "R6 misaligned erase warning", c_mis, 1);
    cs_edge();
  endtask

  task automatic t_unknown();
    send(8'h55, 8'h00);
    chk(c_unk && !c_cmd, "R7 unknown command flag", {c_unk, c_cmd}, 2'b10);
    for (int i = 0; i < 7; i++) begin
      send(8'(8'h10 + i), 8'hEE);
      chk(quiet(), "R7 unknown transaction ignored", {c_addr, c_data}, 0);
    end
    cs_edge();
    chk(!c_sum, "R7 no summary after unknown", c_sum, 0);
  endtask

  task automatic t_plain();
    send(8'h05, 8'h00);
    chk(c_cmd && c_code == 8'h05, "R11 status read command", c_code, 8'h05);
    for (int i = 0; i < 6; i++) send(8'h00, 8'h83);
    chk(quiet(), "R11 status read bytes silent", c_data, 0);
    cs_edge();
    chk(!c_sum, "R11 no summary for status read", c_sum, 0);
    send(8'h9F, 8'h00);
    chk(c_cmd && c_code == 8'h9F, "R11 identify command", c_code, 8'h9F);
    for (int i = 0; i < 4; i++) send(8'h00, 8'hC2);
    chk(quiet(), "R11 identify bytes silent", c_addr, 0);
    cs_edge();
  endtask

  task automatic t_cs_reset();
    send(8'h03, 8'h00); send(8'h12, 8'h00);
    cs_edge();
    chk(!c_sum, "R10 abort mid address no summary", c_sum, 0);
    send(8'h03, 8'h00);
    chk(c_cmd, "R10 command after abort", c_cmd, 1);
    send(8'hAA, 8'h00); send(8'hBB, 8'h00); send(8'hCC, 8'h00);
    chk(c_addr && c_aout == 24'hAABBCC, "R10 fresh address after abort", c_aout, 24'hAABBCC);
    // byte together with strobe is ignored
    @(negedge clk);
    cs_chg = 1'b1; byte_vld = 1'b1; mosi_byte = 8'h03;
    #1 capture();
    chk(quiet() && !c_sum, "R10 byte with strobe ignored", {c_cmd, c_sum}, 0);
    @(posedge clk); #1 cs_chg = 1'b0; byte_vld = 1'b0;
    send(8'h06, 8'h00);
    chk(c_cmd && c_code == 8'h06, "R10 next byte is command", c_code, 8'h06);
    cs_edge();
  endtask

  task automatic t_saturate();
    send(8'h03, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00);
    @(negedge clk);
    byte_vld = 1'b1; mosi_byte = 8'h00; miso_byte = 8'h42;
    repeat (65540) @(negedge clk);
    byte_vld = 1'b0;
    cs_edge();
    chk(c_sum && c_scnt == 16'hFFFF, "R9 count saturates", c_scnt, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_read();
    t_fast();
    t_prog();
    t_dual();
    t_erase();
    t_unknown();
    t_plain();
    t_cs_reset();
    t_saturate();
    done = 1;
    report();
  end

endmodule